// File: doc/BRIEF.md
# Pulse-Swallow Integer-N Feedback Divider

This block divides a high-rate input clock by an integer N with a dual-modulus prescaler. The prescaler divides by 32 or 33. A swallow counter and a programmable counter switch its modulus. In each output period the prescaler first runs A cycles of 33 input clocks, then B-A cycles of 32 input clocks. One feedback pulse is therefore issued every N = 32*B + A input clocks. A companion reference divider runs from the same clock and issues one pulse every R clocks. Together the two pulse trains feed a phase comparison stage, which sits outside this block.

The ratio inputs are plain levels from a configuration latch. They are sampled only at the reload point of each divider, so a value that changes mid-period applies from the next period. A hold input stands for counter reset or power-down. While it is high, both dividers stay at their load point, keep capturing the current ratios and emit nothing. On the first edge with hold low, both dividers start counting together. Ratio sets that are not allowed are replaced by the smallest legal ratio, and an error flag is raised. No streaming data crosses the edge of this block, so every pin is a plain control or status level with no valid/ready handshake.

Top module: `psw_feedback_divider`

## Requirements
- R1: After hold falls, the first fb_pulse appears exactly 32*B+A clock edges after the first edge sampled with hold low. Each following fb_pulse comes exactly 32*B+A edges after the one before, for any legal A in 0..31 and B in 3..1023 with A <= B.
- R2: The prescaler modulus is 33 for the first A prescaler cycles of a period and 32 for the rest. A swallow count of 0 therefore gives a period of exactly 32*B, and A equal to B gives exactly 33*B.
- R3: fb_pulse is high for exactly one clock cycle per period.
- R4: ref_pulse is high for one clock cycle. It comes R edges after hold is released and every R edges after that.
- R5: While hold is sampled high, neither pulse is asserted, both dividers stay at their load point, and the ratio inputs are captured on every held edge.
- R6: A change of swallow_cnt or prog_cnt in mid-period does not alter that period. The new feedback ratio first applies to the period after the next fb_pulse.
- R7: A change of ref_cnt in mid-period does not alter that period. The new reference ratio applies from the period after the next ref_pulse.
- R8: When prog_cnt < 3 or swallow_cnt > prog_cnt at a feedback reload, the divider uses A=0, B=3 (period 96) and fb_cfg_err reads 1 from that reload on. A legal set loaded at a reload clears the flag.
- R9: When ref_cnt < 2 at a reference reload, the divider uses R=2 and ref_cfg_err reads 1. A legal value loaded at a reload clears it.
- R10: While rst_n is low, fb_pulse, ref_pulse, fb_cfg_err and ref_cfg_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Counter reset / power-down: holds both dividers at their load point |
| swallow_cnt | input | 5 | Swallow count A |
| prog_cnt | input | 10 | Programmable count B |
| ref_cnt | input | 10 | Reference ratio R |
| fb_pulse | output | 1 | One-cycle feedback pulse every N clocks |
| ref_pulse | output | 1 | One-cycle reference pulse every R clocks |
| fb_cfg_err | output | 1 | Feedback ratio set in use was illegal and was clamped |
| ref_cfg_err | output | 1 | Reference ratio in use was illegal and was clamped |

## Verification
The hardest case to reach from the ports is a ratio change that lands strictly inside a running period. The bench releases hold with one (A, B, R) set and waits for the first feedback pulse. A few cycles later, well before the next terminal count, it applies a second set. The scoreboard then expects one more period at the old ratio before the new one. The reference side is predicted from the ratio value seen at each of its terminal edges. A hold pulse dropped into the middle of a long period checks that the partial period is discarded and that both dividers restart in alignment.

// File: rtl/psw_div_pkg.sv
package psw_div_pkg;
  localparam int SWALLOW_W_DEF = 5;
  localparam int PROG_W_DEF    = 10;
  localparam int REF_W_DEF     = 10;
  localparam int MIN_PROG_DEF  = 3;
  localparam int MIN_REF_DEF   = 2;

  typedef enum logic {
    MOD_BASE = 1'b0,
    MOD_PLUS = 1'b1
  } psw_mod_e;
endpackage

// File: rtl/psw_prescaler.sv
module psw_prescaler
  import psw_div_pkg::*;
#(
  parameter int SWALLOW_W = SWALLOW_W_DEF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hold,
  input  psw_mod_e mod_sel,
  output logic     cyc_end
);
  localparam int BASE_MOD = 1 << SWALLOW_W;
  localparam int CNT_W    = SWALLOW_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_val;

  // the plus modulus spends one extra input clock per prescaler cycle
  always_comb begin
    if (mod_sel == MOD_PLUS) last_val = CNT_W'(BASE_MOD);
    else                     last_val = CNT_W'(BASE_MOD - 1);
  end

  assign cyc_end = !hold && (cnt == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (hold || cyc_end)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/psw_swallow_ctrl.sv
module psw_swallow_ctrl
  import psw_div_pkg::*;
#(
  parameter int SWALLOW_W = SWALLOW_W_DEF,
  parameter int PROG_W    = PROG_W_DEF,
  parameter int MIN_PROG  = MIN_PROG_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold,
  input  logic [SWALLOW_W-1:0] a_in,
  input  logic [PROG_W-1:0]    b_in,
  input  logic                 presc_end,
  output psw_mod_e             mod_sel,
  output logic                 period_end,
  output logic                 cfg_bad
);
  logic [SWALLOW_W-1:0] a_rem;
  logic [PROG_W-1:0]    b_rem;
  logic                 set_bad;
  logic [SWALLOW_W-1:0] a_ld;
  logic [PROG_W-1:0]    b_ld;
  logic                 reload;

  // illegal sets fall back to the smallest legal ratio
  always_comb begin
    set_bad = (b_in < PROG_W'(MIN_PROG)) || (PROG_W'(a_in) > b_in);
    a_ld    = set_bad ? '0 : a_in;
    b_ld    = set_bad ? PROG_W'(MIN_PROG) : b_in;
  end

  assign mod_sel    = (a_rem != '0) ? MOD_PLUS : MOD_BASE;
  assign period_end = presc_end && (b_rem == PROG_W'(1));
  assign reload     = hold || period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rem   <= '0;
      b_rem   <= PROG_W'(MIN_PROG);
      cfg_bad <= 1'b0;
    end else if (reload) begin
      a_rem   <= a_ld;
      b_rem   <= b_ld;
      cfg_bad <= set_bad;
    end else if (presc_end) begin
      b_rem <= b_rem - 1'b1;
      if (a_rem != '0) a_rem <= a_rem - 1'b1;
    end
  end
endmodule

// File: rtl/psw_ref_div.sv
module psw_ref_div
  import psw_div_pkg::*;
#(
  parameter int REF_W   = REF_W_DEF,
  parameter int MIN_REF = MIN_REF_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [REF_W-1:0] r_in,
  output logic             ref_end,
  output logic             cfg_bad
);
  logic [REF_W-1:0] r_rem;
  logic             r_bad;
  logic [REF_W-1:0] r_ld;

  always_comb begin
    r_bad = r_in < REF_W'(MIN_REF);
    r_ld  = r_bad ? REF_W'(MIN_REF) : r_in;
  end

  assign ref_end = !hold && (r_rem == REF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_rem   <= REF_W'(MIN_REF);
      cfg_bad <= 1'b0;
    end else if (hold || ref_end) begin
      r_rem   <= r_ld;
      cfg_bad <= r_bad;
    end else begin
      r_rem <= r_rem - 1'b1;
    end
  end
endmodule

// File: rtl/psw_feedback_divider.sv
module psw_feedback_divider
  import psw_div_pkg::*;
#(
  parameter int SWALLOW_W = SWALLOW_W_DEF,
  parameter int PROG_W    = PROG_W_DEF,
  parameter int REF_W     = REF_W_DEF,
  parameter int MIN_PROG  = MIN_PROG_DEF,
  parameter int MIN_REF   = MIN_REF_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold,
  input  logic [SWALLOW_W-1:0] swallow_cnt,
  input  logic [PROG_W-1:0]    prog_cnt,
  input  logic [REF_W-1:0]     ref_cnt,
  output logic                 fb_pulse,
  output logic                 ref_pulse,
  output logic                 fb_cfg_err,
  output logic                 ref_cfg_err
);
  psw_mod_e mod_sel;
  logic     presc_end;
  logic     period_end;
  logic     ref_end;

  psw_prescaler #(.SWALLOW_W(SWALLOW_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .mod_sel (mod_sel),
    .cyc_end (presc_end)
  );

  psw_swallow_ctrl #(
    .SWALLOW_W (SWALLOW_W),
    .PROG_W    (PROG_W),
    .MIN_PROG  (MIN_PROG)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .a_in       (swallow_cnt),
    .b_in       (prog_cnt),
    .presc_end  (presc_end),
    .mod_sel    (mod_sel),
    .period_end (period_end),
    .cfg_bad    (fb_cfg_err)
  );

  psw_ref_div #(.REF_W(REF_W), .MIN_REF(MIN_REF)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .r_in    (ref_cnt),
    .ref_end (ref_end),
    .cfg_bad (ref_cfg_err)
  );

  // registered pulses: one clock wide, issued on the terminal edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_pulse  <= 1'b0;
      ref_pulse <= 1'b0;
    end else begin
      fb_pulse  <= period_end;
      ref_pulse <= ref_end;
    end
  end
endmodule

// File: rtl/psw_feedback_divider_chk.sv
module psw_feedback_divider_chk #(
  parameter int SWALLOW_W = 5,
  parameter int PROG_W    = 10,
  parameter int REF_W     = 10,
  parameter int MIN_PROG  = 3,
  parameter int MIN_REF   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hold,
  input logic [SWALLOW_W-1:0] swallow_cnt,
  input logic [PROG_W-1:0]    prog_cnt,
  input logic [REF_W-1:0]     ref_cnt,
  input logic                 fb_pulse,
  input logic                 ref_pulse,
  input logic                 fb_cfg_err,
  input logic                 ref_cfg_err
);
  logic n_set_bad;
  assign n_set_bad = (prog_cnt < PROG_W'(MIN_PROG)) || (PROG_W'(swallow_cnt) > prog_cnt);

  a_r3_fb_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  a_r4_ref_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!fb_pulse && !ref_pulse));

  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && n_set_bad) |=> fb_cfg_err);

  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !n_set_bad) |=> !fb_cfg_err);

  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && (ref_cnt < REF_W'(MIN_REF))) |=> ref_cfg_err);

  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && (ref_cnt >= REF_W'(MIN_REF))) |=> !ref_cfg_err);
endmodule

bind psw_feedback_divider psw_feedback_divider_chk #(
  .SWALLOW_W (SWALLOW_W),
  .PROG_W    (PROG_W),
  .REF_W     (REF_W),
  .MIN_PROG  (MIN_PROG),
  .MIN_REF   (MIN_REF)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold        (hold),
  .swallow_cnt (swallow_cnt),
  .prog_cnt    (prog_cnt),
  .ref_cnt     (ref_cnt),
  .fb_pulse    (fb_pulse),
  .ref_pulse   (ref_pulse),
  .fb_cfg_err  (fb_cfg_err),
  .ref_cfg_err (ref_cfg_err)
);

// File: tb/tb_psw_feedback_divider.sv
`timescale 1ns/1ps
module tb_psw_feedback_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold = 1'b1;
  logic [4:0] swallow_cnt = 5'd0;
  logic [9:0] prog_cnt = 10'd3;
  logic [9:0] ref_cnt = 10'd2;
  logic       fb_pulse, ref_pulse, fb_cfg_err, ref_cfg_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  psw_feedback_divider dut (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .swallow_cnt(swallow_cnt), .prog_cnt(prog_cnt), .ref_cnt(ref_cnt),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse),
    .fb_cfg_err(fb_cfg_err), .ref_cfg_err(ref_cfg_err)
  );

  function automatic bit n_bad(int a, int b);
    return (b < 3) || (a > b);
  endfunction
  function automatic int n_ratio(int a, int b);
    return n_bad(a, b) ? 96 : 32 * b + a;
  endfunction
  function automatic int r_ratio(int r);
    return (r < 2) ? 2 : r;
  endfunction

  task automatic check(bit ok, string tag, int got, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- monitor ----------------
  int         fcnt = 0, rcnt = 0, rexp = 2;
  bit         hold_prev = 1, fb_prev = 0, ref_prev = 0;
  logic [9:0] r_prev = 10'd2;

  always @(negedge clk) begin
    if (!rst_n) begin
      fcnt = 0; rcnt = 0; hold_prev = hold; r_prev = ref_cnt;
      fb_prev = 0; ref_prev = 0;
    end else begin
      if (fb_prev) check(!fb_pulse, "R3 fb width", int'(fb_pulse), 0);
      if (hold_prev) begin
        // R5: the edge just taken was held
        if (fb_pulse || ref_pulse) check(0, "R5 pulse under hold", 1, 0);
        fcnt = 0; rcnt = 0; rexp = r_ratio(int'(r_prev));
      end else begin
        fcnt++; rcnt++;
        if (fb_pulse) begin
          if (exp_q.size() == 0) check(0, "R1 unexpected fb_pulse", fcnt, 0);
          else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(fcnt == e, t, fcnt, e);
          end
          fcnt = 0;
        end
        if (ref_pulse) begin
          // R4 R7 R9: ratio of the period just ended
          check(rcnt == rexp, "R4/R7/R9 ref period", rcnt, rexp);
          rcnt = 0;
          rexp = r_ratio(int'(r_prev));
        end
      end
      fb_prev = fb_pulse; ref_prev = ref_pulse;
      hold_prev = hold; r_prev = ref_cnt;
    end
  end

  // ---------------- driver ----------------
  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic enter_hold();
    tick(1);
    hold = 1'b1;
  endtask

  task automatic load(int a, int b, int r);
    swallow_cnt = 5'(a); prog_cnt = 10'(b); ref_cnt = 10'(r);
  endtask

  task automatic push(int e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
  endtask

  task automatic check_flags(int a, int b, int r);
    @(negedge clk);
    check(fb_cfg_err == n_bad(a, b), "R8 fb_cfg_err", int'(fb_cfg_err), int'(n_bad(a, b)));
    check(ref_cfg_err == (r < 2), "R9 ref_cfg_err", int'(ref_cfg_err), int'(r < 2));
  endtask

  task automatic session(int a, int b, int r, int k, string t);
    enter_hold();
    load(a, b, r);
    tick(2);
    check_flags(a, b, r);
    for (int i = 0; i < k; i++) push(n_ratio(a, b), t);
    tick(1);
    hold = 1'b0;
    drain();
    enter_hold();
  endtask

  initial begin
    tick(3);
    @(negedge clk);
    check(!fb_pulse && !ref_pulse, "R10 pulses in reset", int'(fb_pulse | ref_pulse), 0);
    check(!fb_cfg_err && !ref_cfg_err, "R10 flags in reset", int'(fb_cfg_err | ref_cfg_err), 0);
    tick(1);
    rst_n = 1'b1;
    tick(2);

    session(0, 3, 2, 3, "R2 A=0 period");
    session(3, 3, 5, 3, "R2 A=B period");
    session(5, 10, 7, 3, "R1 period");
    session(31, 40, 1023, 2, "R1 period");
    session(31, 1023, 3, 1, "R1 max period");

    // R6 R7: ratio change inside a running period
    enter_hold();
    load(2, 4, 4);
    tick(2);
    push(n_ratio(2, 4), "R6 old ratio kept");
    push(n_ratio(2, 4), "R6 old ratio kept");
    push(n_ratio(9, 20), "R6 new ratio");
    push(n_ratio(9, 20), "R6 new ratio");
    hold = 1'b0;
    while (exp_q.size() > 3) @(posedge clk);
    tick(20);
    load(9, 20, 9);
    drain();
    enter_hold();

    // R8 R9: illegal sets clamp and flag
    session(7, 5, 1, 2, "R8 clamp A>B");
    session(0, 2, 0, 2, "R8 clamp B<3");
    session(1, 3, 2, 2, "R8 legal after clamp");

    // R5: hold dropped into a long period discards it
    enter_hold();
    load(0, 50, 600);
    tick(2);
    hold = 1'b0;
    tick(200);
    hold = 1'b1;
    tick(10);
    session(4, 6, 6, 2, "R5 restart after hold");

    tick(5);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog got=%0d exp=%0d", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule